// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Control

This block drives a bank of quasi-bidirectional I/O pins that have no direction register. Each bit keeps an output latch. The latch value selects one of two pin states. A latch of 0 sinks the pin low through a pull-down. A latch of 1 leaves only a weak pull-up, so an external source can pull the pin low and the pin serves as an input.

When a bit goes from 0 to 1, a strong pull-up switches on to give the pin a fast rising edge. That strong pull-up is released at the next falling edge of the serial clock. The current sources themselves sit outside the block; here each one appears only as an enable output.

Reads return the level actually seen on the pin, not the latch. The pin level first passes through a synchronizer. It is captured on a read strobe and then held until the next read strobe.

Top module: `qb_port_ctrl`

## Requirements
- R1: After reset every latch is 1. `weak_up_o` is all ones, `pull_down_o` and `strong_up_o` are all zeros, and `rd_data_o` is all ones.
- R2: When `wr_en_i` is high at a clock edge, each bit of `pull_down_o` equals the inverse of the matching bit of `wr_data_i` from the cycle after that edge onward.
- R3: Writing 1 to a bit whose latch was 0 sets that bit of `strong_up_o` in the cycle after the write. The bit's `weak_up_o` is also 1.
- R4: A falling edge on `scl_i` clears every bit of `strong_up_o`. The clear takes effect at the third clock edge after the fall: two edges for the synchronizer and one for the edge detector.
- R5: Writing 1 to a bit whose latch is already 1 does not start a strong pull-up. If a strong pull-up is already running on that bit, it stays on.
- R6: For every bit, `strong_up_o` and `pull_down_o` are never both 1. Writing 0 ends a running strong pull-up on that bit.
- R7: A read strobe on `rd_en_i` loads `rd_data_o` with the pin level sampled two clock edges earlier, not with the latch. `rd_data_o` does not change while no read strobe is present.
- R8: A pin whose latch is 0 reads as 0 even while an external source drives it high. A pin whose latch is 1 reads the level the external source drives.
- R9: While `wr_en_i` is low, changes on `wr_data_i` have no effect on `weak_up_o`, `pull_down_o` or `strong_up_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe; loads the latches |
| wr_data_i | input | WIDTH | Data for the latches |
| rd_en_i | input | 1 | Read strobe; captures the pin levels |
| scl_i | input | 1 | Serial clock; its falling edge ends the strong pull-ups |
| pin_i | input | WIDTH | Levels seen on the pins |
| pull_down_o | output | WIDTH | Pull-down enable per pin |
| weak_up_o | output | WIDTH | Weak pull-up enable per pin |
| strong_up_o | output | WIDTH | Transient strong pull-up enable per pin |
| rd_data_o | output | WIDTH | Captured pin levels |

## Verification
The bench targets four corner cases:

- **Rewrite of an already-high bit.** A design that started a strong pull-up on every written 1 would show a spurious pulse. A design that cleared a running pull-up on such a write would cut off the rising edge.
- **Timing of the strong pull-up release.** The bench checks the exact edge at which the pull-up drops after a serial clock fall. A missing synchronizer stage, or a release on the wrong clock edge, shifts that edge and is caught.
- **A low latch against an external high driver.** A design that read back the latch, or that let the input override the pull-down, returns the wrong value.
- **Data changes with no strobe.** The bench changes `wr_data_i` and the pin levels without a write or read strobe. A design that let either path through would alter its outputs.

// File: rtl/qb_pkg.sv
package qb_pkg;
  typedef struct packed {
    logic pd;
    logic wk;
    logic st;
  } qb_drv_t;
endpackage

// File: rtl/qb_sync.sv
module qb_sync #(
  parameter int unsigned         W       = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic [W-1:0]        RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qb_pin_cell.sv
module qb_pin_cell
  import qb_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_en_i,
  input  logic    wr_bit_i,
  input  logic    scl_fall_i,
  output qb_drv_t drv_o
);
  logic latch_q;
  logic strong_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q  <= 1'b1;
      strong_q <= 1'b0;
    end else if (wr_en_i) begin
      latch_q <= wr_bit_i;
      // 0->1 starts the boost, 0 kills it, 1->1 keeps it
      if (!wr_bit_i)     strong_q <= 1'b0;
      else if (!latch_q) strong_q <= 1'b1;
      else if (scl_fall_i) strong_q <= 1'b0;
    end else if (scl_fall_i) begin
      strong_q <= 1'b0;
    end
  end

  assign drv_o.pd = ~latch_q;
  assign drv_o.wk = latch_q;
  assign drv_o.st = strong_q;
endmodule

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl
  import qb_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             scl_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pull_down_o,
  output logic [WIDTH-1:0] weak_up_o,
  output logic [WIDTH-1:0] strong_up_o,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic             scl_s;
  logic             scl_q;
  logic             scl_fall;
  logic [WIDTH-1:0] pin_s;
  qb_drv_t          drv [WIDTH];

  qb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
  );

  qb_sync #(.W(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL(ALL_ONES)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b1;
    else         scl_q <= scl_s;
  end

  assign scl_fall = scl_q & ~scl_s;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    qb_pin_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_bit_i  (wr_data_i[i]),
      .scl_fall_i(scl_fall),
      .drv_o     (drv[i])
    );
    assign pull_down_o[i] = drv[i].pd;
    assign weak_up_o[i]   = drv[i].wk;
    assign strong_up_o[i] = drv[i].st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= ALL_ONES;
    else if (rd_en_i) rd_data_o <= pin_s;
  end
endmodule

// File: rtl/qb_port_ctrl_chk.sv
module qb_port_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic             rd_en_i,
  input logic [WIDTH-1:0] pull_down_o,
  input logic [WIDTH-1:0] weak_up_o,
  input logic [WIDTH-1:0] strong_up_o,
  input logic [WIDTH-1:0] rd_data_o
);
  assert_write_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> pull_down_o == ~$past(wr_data_i));

  assert_boost_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (strong_up_o & $past(wr_data_i & ~weak_up_o)) == $past(wr_data_i & ~weak_up_o));

  assert_no_boost_without_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (strong_up_o & ~$past(strong_up_o)) == '0);

  assert_no_fight_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strong_up_o & pull_down_o) == '0);

  assert_read_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  assert_latch_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(weak_up_o) && $stable(pull_down_o));
endmodule

bind qb_port_ctrl qb_port_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_en_i(rd_en_i), .pull_down_o(pull_down_o), .weak_up_o(weak_up_o),
  .strong_up_o(strong_up_o), .rd_data_o(rd_data_o)
);

// File: tb/tb_qb_port_ctrl.sv
module tb_qb_port_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic         scl = 1'b1;
  logic [W-1:0] ext_en = '0;
  logic [W-1:0] ext_val = '0;
  logic [W-1:0] pin;
  logic [W-1:0] pull_down, weak_up, strong_up, rd_data;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_latch = '1;
  logic [W-1:0] m_strong = '0;

  always #2 clk = ~clk;

  // pin model: the sink wins, then the external driver, else the weak pull-up
  assign pin = ~pull_down & (~ext_en | ext_val);

  qb_port_ctrl #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .scl_i(scl), .pin_i(pin), .pull_down_o(pull_down),
    .weak_up_o(weak_up), .strong_up_o(strong_up), .rd_data_o(rd_data)
  );

  function automatic logic [W-1:0] exp_pin(logic [W-1:0] lt, logic [W-1:0] en,
                                           logic [W-1:0] v);
    return lt & (~en | v);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check_drive(string req);
    chk({req, " pull_down"}, pull_down, ~m_latch);
    chk({req, " weak_up"},   weak_up,   m_latch);
    chk({req, " strong_up"}, strong_up, m_strong);
  endtask

  task automatic do_write(logic [W-1:0] d, string req);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
    m_strong = d & (~m_latch | m_strong);
    m_latch  = d;
    check_drive(req);
  endtask

  task automatic scl_fall_check();
    scl = 1'b0;
    tick(); tick();
    chk("R4 boost held two edges", strong_up, m_strong);
    tick();
    m_strong = '0;
    chk("R4 boost released", strong_up, '0);
    scl = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic do_read(logic [W-1:0] en, logic [W-1:0] v, string req);
    logic [W-1:0] exp;
    ext_en = en; ext_val = v;
    tick(); tick();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    exp = exp_pin(m_latch, en, v);
    chk(req, rd_data, exp);
    ext_val = ~v; ext_en = '1;
    tick(); tick(); tick();
    chk("R7 read held without strobe", rd_data, exp);
    ext_en = '0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk); @(negedge clk);
    check_drive("R1 reset");
    chk("R1 reset rd_data", rd_data, '1);
    rst_n = 1'b1;
    tick();

    do_write(8'h00, "R2 all low");
    do_write(8'hA5, "R3 boost on rising bits");
    do_write(8'hFF, "R5 keep running boost");
    do_write(8'h0F, "R6 zero ends boost");
    do_write(8'hFF, "R5 mix start and keep");
    scl_fall_check();
    do_write(8'hFF, "R5 no boost on 1 over 1");

    wr_data = 8'h00;
    tick(); wr_data = 8'h3C; tick();
    check_drive("R9 data without strobe");

    do_write(8'h0F, "R2 half low");
    scl_fall_check();
    do_read(8'hFF, 8'hFF, "R8 low latch beats external high");
    do_read(8'hF0, 8'h50, "R7 external pattern on inputs");
    do_read(8'h00, 8'h00, "R7 weak pull-up reads high");

    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] d, en, v;
      d = W'($urandom); en = W'($urandom); v = W'($urandom);
      do_write(d, "R3 random write");
      scl_fall_check();
      do_read(en, v, "R8 random read");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule